// File: doc/BRIEF.md
# Serial Work Loader and Nonce Sweeper

This block sits between a byte-wide serial receiver and a hashing core. Every byte that arrives is pushed into the low end of a 512-bit work register. Everything already held moves up one byte, and the oldest byte is dropped. The whole register is presented to the hashing core on every cycle. There is no framing and no count of bytes, so the core always sees whatever the register holds at that moment, even partway through an upload.

The same byte strobe restarts a 32-bit nonce sweep. Two boards share the nonce space by parity. The lowest nonce bit always equals the board identity input, and the sweep steps by two. The sweep advances once per clock while the core signals ready. It runs through any nonce the core may find and stops only at a configurable end value. At that point an exhausted flag is raised, and it stays raised until the next byte arrives. A dropped byte leaves misaligned work in the register. No recovery logic exists: a later complete 64-byte push realigns it.

Top module: `work_sweep_top`

## Requirements
- R1: While reset is held, and after it is released, the work word is all zeros, the nonce bits [31:1] are zero, and both the active and exhausted flags are low.
- R2: A cycle with `rx_valid` high places `rx_byte` in work bits [7:0]. The previous bits [503:0] move to bits [511:8], and the previous bits [511:504] are lost. The result is visible one clock later.
- R3: Without a byte strobe the work word holds its value.
- R4: A byte strobe in any state (idle, sweeping or exhausted) sets the nonce to {31'b0, board_id}. One clock later the active flag is high and the exhausted flag is low.
- R5: Nonce bit 0 always equals `board_id`.
- R6: While active, each clock with `core_ready` high adds 2 to the nonce. With `core_ready` low, the nonce holds.
- R7: When the active flag is high, `core_ready` is high and nonce bits [31:1] equal `nonce_limit[31:1]`, the next clock clears the active flag, sets the exhausted flag and keeps the nonce at that end value.
- R8: The exhausted flag stays high until the next byte strobe, and the nonce does not move while it is set. Active and exhausted are never high together.
- R9: After a lost byte the work word is misaligned. Any later 64 consecutive bytes leave the work word equal to exactly those bytes, with the first received byte in bits [511:504].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| board_id | input | 1 | Parity of the nonces this board covers |
| nonce_limit | input | 32 | End of the nonce range (bits [31:1] compared) |
| core_ready | input | 1 | Hashing core accepts a nonce this cycle |
| work_word | output | 512 | Live work register |
| nonce | output | 32 | Current nonce |
| sweep_active | output | 1 | Sweep is running |
| sweep_done | output | 1 | End of range reached, held until next byte |

## Verification
The step and stop properties assume that `nonce_limit` does not change while a sweep runs. They also assume that `board_id` changes only between sweeps, because a change mid-sweep would move the nonce parity under a running count. The stimulus sets both values only just before the byte that starts a sweep, and holds them until the next byte. Byte strobes may arrive back to back or be spread out, and the bench uses both. `core_ready` is toggled freely, since the design has to tolerate any pattern on it.

// File: rtl/work_sweep_pkg.sv
package work_sweep_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORK_BYTES = 64;
  localparam int unsigned NONCE_W    = 32;
endpackage

// File: rtl/ws_reset_sync.sv
module ws_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ws_work_shift.sv
module ws_work_shift #(
  parameter int unsigned BYTES = work_sweep_pkg::WORK_BYTES,
  parameter int unsigned BW    = work_sweep_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [BW-1:0]     din,
  output logic [BYTES*BW-1:0] work
);
  localparam int unsigned TOTAL = BYTES * BW;

  logic [BYTES-1:0][BW-1:0] lane_q;
  logic [BYTES-1:0][BW-1:0] lane_d;

  // lane 0 takes the new byte, every higher lane takes its lower neighbour
  assign lane_d[0] = din;
  for (genvar g = 1; g < BYTES; g++) begin : g_lane
    assign lane_d[g] = lane_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lane_q <= '0;
    else if (shift_en) lane_q <= lane_d;
  end

  assign work = lane_q;

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (work[BW-1:0] == $past(din)) &&
                 (work[TOTAL-1:BW] == $past(work[TOTAL-BW-1:0])));
  // R3
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(work));
endmodule

// File: rtl/ws_nonce_sweep.sv
module ws_nonce_sweep #(
  parameter int unsigned NW = work_sweep_pkg::NONCE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          ready,
  input  logic          id_bit,
  input  logic [NW-1:0] limit,
  output logic [NW-1:0] nonce,
  output logic          active,
  output logic          done
);
  localparam int unsigned HW = NW - 1;

  logic [HW-1:0] hi_q, hi_d;
  logic          act_q, act_d;
  logic          done_q, done_d;
  logic          at_end;
  logic          step;

  assign at_end = (hi_q == limit[NW-1:1]);
  assign step   = act_q & ready;

  always_comb begin
    hi_d   = hi_q;
    act_d  = act_q;
    done_d = done_q;
    if (restart) begin
      hi_d   = '0;
      act_d  = 1'b1;
      done_d = 1'b0;
    end else if (step) begin
      if (at_end) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        hi_d = hi_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign nonce  = {hi_q, id_bit};
  assign active = act_q;
  assign done   = done_q;

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (nonce[NW-1:1] == '0) && active && !done);
  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && active && ready && (nonce[NW-1:1] != limit[NW-1:1]))
      |=> (nonce[NW-1:1] == $past(nonce[NW-1:1]) + HW'(1)));
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !(active && ready)) |=> $stable(nonce[NW-1:1]));
  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && active && ready && (nonce[NW-1:1] == limit[NW-1:1]))
      |=> done && !active && $stable(nonce[NW-1:1]));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && done));
endmodule

// File: rtl/work_sweep_top.sv
module work_sweep_top #(
  parameter int unsigned WORK_BYTES = work_sweep_pkg::WORK_BYTES,
  parameter int unsigned BYTE_W     = work_sweep_pkg::BYTE_W,
  parameter int unsigned NONCE_W    = work_sweep_pkg::NONCE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [BYTE_W-1:0]            rx_byte,
  input  logic                         board_id,
  input  logic [NONCE_W-1:0]           nonce_limit,
  input  logic                         core_ready,
  output logic [WORK_BYTES*BYTE_W-1:0] work_word,
  output logic [NONCE_W-1:0]           nonce,
  output logic                         sweep_active,
  output logic                         sweep_done
);
  logic srst_n;

  ws_reset_sync i_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ws_work_shift #(.BYTES(WORK_BYTES), .BW(BYTE_W)) i_work (
    .clk      (clk),
    .rst_n    (srst_n),
    .shift_en (rx_valid),
    .din      (rx_byte),
    .work     (work_word)
  );

  ws_nonce_sweep #(.NW(NONCE_W)) i_sweep (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (rx_valid),
    .ready   (core_ready),
    .id_bit  (board_id),
    .limit   (nonce_limit),
    .nonce   (nonce),
    .active  (sweep_active),
    .done    (sweep_done)
  );

  // R5
  parity_chk: assert property (@(posedge clk) disable iff (!srst_n)
    nonce[0] == board_id);
endmodule

// File: tb/test_work_sweep_top.sv
`timescale 1ns/1ps
module test_work_sweep_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         rx_valid;
  logic [7:0]   rx_byte;
  logic         board_id;
  logic [31:0]  nonce_limit;
  logic         core_ready;
  logic [511:0] work_word;
  logic [31:0]  nonce;
  logic         sweep_active;
  logic         sweep_done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string        tag;
    logic [511:0] work;
    logic [31:0]  nonce;
    logic         act;
    logic         done;
  } exp_t;
  exp_t sb_q[$];

  logic [511:0] m_work;
  logic [30:0]  m_hi;
  logic         m_act, m_done;

  always #10 clk = ~clk;

  work_sweep_top i_work_sweep_top (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .board_id(board_id), .nonce_limit(nonce_limit), .core_ready(core_ready),
    .work_word(work_word), .nonce(nonce), .sweep_active(sweep_active),
    .sweep_done(sweep_done)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, advances the model, queues the expectation
  task automatic drive(input bit v, input logic [7:0] b, input bit rdy, input string tag);
    exp_t e;
    @(negedge clk);
    rx_valid = v; rx_byte = b; core_ready = rdy;
    @(posedge clk); #1;
    if (v) begin
      m_work = {m_work[503:0], b};
      m_hi = '0; m_act = 1'b1; m_done = 1'b0;
    end else if (m_act && rdy) begin
      if (m_hi == nonce_limit[31:1]) begin m_act = 1'b0; m_done = 1'b1; end
      else m_hi = m_hi + 31'd1;
    end
    e.tag = tag; e.work = m_work; e.nonce = {m_hi, board_id};
    e.act = m_act; e.done = m_done;
    sb_q.push_back(e);
  endtask

  // monitor: compares once per cycle, well after the edge
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk({e.tag, " R2 work"},   work_word, e.work);
      chk({e.tag, " R6 nonce"},  512'(nonce), 512'(e.nonce));
      chk({e.tag, " R7 active"}, 512'(sweep_active), 512'(e.act));
      chk({e.tag, " R8 done"},   512'(sweep_done), 512'(e.done));
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] pat;
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = '0; board_id = 1'b0;
    nonce_limit = 32'h40; core_ready = 1'b0;
    m_work = '0; m_hi = '0; m_act = 1'b0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1 during reset
    chk("R1 work in reset", work_word, '0);
    chk("R1 flags in reset", 512'({sweep_active, sweep_done}), 512'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 nonce after reset", 512'(nonce[31:1]), 512'(0));
    chk("R1 flags after reset", 512'({sweep_active, sweep_done}), 512'(0));

    // idle with ready: nothing moves (R3, R6)
    for (int i = 0; i < 4; i++) drive(1'b0, 8'h00, 1'b1, "idle");

    // full 64-byte push, back to back, ready high
    pat = '0;
    for (int i = 0; i < 64; i++) begin
      pat = {pat[503:0], 8'(i * 3 + 1)};
      drive(1'b1, 8'(i * 3 + 1), 1'b1, "push");
    end
    chk("R9 full push aligns", work_word, pat);
    chk("R4 nonce restart id0", 512'(nonce), 512'(0));

    // sweep to the end with ready toggling
    for (int i = 0; i < 50; i++) drive(1'b0, 8'h00, (i % 3) != 1, "sweep");
    chk("R7 done at end", 512'({sweep_active, sweep_done}), 512'(2'b01));
    chk("R7 nonce at end", 512'(nonce), 512'(32'h40));
    for (int i = 0; i < 5; i++) drive(1'b0, 8'h00, 1'b1, "hold");
    chk("R8 done held", 512'(sweep_done), 512'(1));

    // odd board, odd limit value: parity of limit ignored
    @(negedge clk); board_id = 1'b1; nonce_limit = 32'h0000_0009;
    drive(1'b1, 8'hA5, 1'b1, "restart");
    chk("R4 nonce restart id1", 512'(nonce), 512'(1));
    chk("R5 nonce bit0", 512'(nonce[0]), 512'(1));
    for (int i = 0; i < 3; i++) drive(1'b0, 8'h00, 1'b0, "stall");
    chk("R6 stall holds", 512'(nonce), 512'(1));
    for (int i = 0; i < 8; i++) drive(1'b0, 8'h00, 1'b1, "run");
    chk("R7 odd end", 512'({nonce, sweep_done}), 512'({32'h9, 1'b1}));

    // mid-sweep restart
    @(negedge clk); nonce_limit = 32'h0000_0100;
    drive(1'b1, 8'h11, 1'b1, "mid0");
    for (int i = 0; i < 6; i++) drive(1'b0, 8'h00, 1'b1, "mid");
    drive(1'b1, 8'h22, 1'b1, "mid1");
    chk("R4 mid-sweep restart", 512'({nonce, sweep_active, sweep_done}),
        512'({32'h1, 1'b1, 1'b0}));

    // lost byte: only 63 of a new 64-byte pattern arrive, spread out
    pat = '0;
    for (int i = 0; i < 64; i++) pat = {pat[503:0], 8'(8'hF0 ^ i)};
    for (int i = 1; i < 64; i++) begin
      drive(1'b1, 8'(8'hF0 ^ i), 1'b0, "lost");
      drive(1'b0, 8'h00, 1'b0, "gap");
    end
    checks++;
    if (work_word === pat) begin
      errors++;
      $display("FAIL R9 misaligned actual=%h expected!=%h", work_word, pat);
    end
    for (int i = 0; i < 64; i++) drive(1'b1, 8'(8'hF0 ^ i), 1'b1, "repush");
    chk("R9 recovered", work_word, pat);

    repeat (2) @(posedge clk);
    #8;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule